// File: doc/BRIEF.md
# Event Hold Buffer with Second-Level Decision

This block parks complete event records in a ring of eight whole-event slots while a second-level trigger decides their fate. Events arrive as a word stream framed by start and end markers. Each finished event waits in its slot until a decision arrives on a separate interface. An accept releases the event to the output stream. A reject discards it silently. Either way the slot then returns to the pool.

Decisions always refer to the oldest event that is complete but not yet decided, so the decision source issues exactly one verdict per event, in arrival order. Accepted events leave in that same order, one word per cycle, with start and end markers. When all slots are taken, the block raises a busy flag and stops taking new events until a slot drains. An event longer than a slot is truncated, and the truncation is flagged on its final output word. A stray decision, meaning one with no complete event waiting, is dropped and tallied in a saturating error counter.

Top module: `event_hold_buffer`

## Requirements
- R1: The pool has NUM_SLOTS (default 8) slots. `busy_o` is 1 exactly when every slot is occupied (filling, waiting, decided or streaming). While busy and no event is open, `in_ready_o` is 0 and no new event is taken.
- R2: A stored event produces no output word before it is accepted.
- R3: An accepted event is output on consecutive cycles in input order. `out_sop_o` is 1 on the first word only and `out_eop_o` is 1 on the last word only. A one-word event has both set on the same word.
- R4: A rejected event produces no output and its slot is released.
- R5: Each verdict applies to the oldest undecided complete event. Accepted events leave in arrival order, whatever rejects sit between them.
- R6: An event counts as complete from the cycle after its end-marker word is taken. A decision (`dec_valid_i`=1) with no complete undecided event has no effect on any event and raises `err_cnt_o` by one, saturating at all ones. `err_cnt_o` changes only on such a decision.
- R7: An event longer than SLOT_WORDS (default 16) words is output as its first SLOT_WORDS words, with `out_ovf_o`=1 on the end word. `out_ovf_o` is 0 on all other words and on events of SLOT_WORDS words or fewer.
- R8: A decision and an incoming event word in the same cycle are both processed.
- R9: After reset: `out_valid_o`=0, `busy_o`=0, `in_ready_o`=1 and `err_cnt_o`=0.
- R10: A slot is released after the last word of its accepted event has been output, or when its rejected event is dropped. A released slot can take a new event.
- R11: When no event is open, a word without `in_sop_i`=1 is taken and discarded. It creates no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input word valid |
| in_sop_i | input | 1 | First word of an event |
| in_eop_i | input | 1 | Last word of an event |
| in_data_i | input | DATA_W | Input word |
| in_ready_o | output | 1 | Input word is taken this cycle when valid |
| busy_o | output | 1 | All slots occupied |
| dec_valid_i | input | 1 | Decision strobe |
| dec_accept_i | input | 1 | 1 = accept, 0 = reject |
| out_valid_o | output | 1 | Output word valid |
| out_sop_o | output | 1 | First output word of an event |
| out_eop_o | output | 1 | Last output word of an event |
| out_ovf_o | output | 1 | Event was truncated (end word only) |
| out_data_o | output | DATA_W | Output word |
| err_cnt_o | output | ERR_W | Count of decisions that found no waiting event |

## Verification
The bench fills every slot and then tries a ninth event. A design with a wrong occupancy test would overwrite a waiting event or hang with the pool half empty. It mixes rejects between accepts, so any verdict misrouted to the wrong slot shows up as missing or reordered events at the scoreboard. It sends events of exactly and just over the slot size, which catch off-by-one truncation and a stale overflow flag. It also issues stray decisions, including one after an unframed word, and a verdict while another event is still arriving. A design that counted those wrongly, or dropped one of the concurrent actions, would miscount errors or lose an event.

// File: rtl/eb_pkg.sv
package eb_pkg;
  typedef enum logic [2:0] {
    SLOT_FREE,
    SLOT_FILL,
    SLOT_PEND,
    SLOT_ACC,
    SLOT_REJ
  } slot_state_e;
endpackage

// File: rtl/eb_writer.sv
module eb_writer #(
  parameter int NUM_SLOTS  = 8,
  parameter int SLOT_WORDS = 16,
  parameter int DATA_W     = 16,
  parameter int SLOT_W     = $clog2(NUM_SLOTS),
  parameter int IDX_W      = $clog2(SLOT_WORDS),
  parameter int LEN_W      = $clog2(SLOT_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              slot_free_i,
  output logic              in_ready_o,
  output logic              wr_en_o,
  output logic [SLOT_W-1:0] wr_slot_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              start_o,
  output logic              done_o,
  output logic [LEN_W-1:0]  done_len_o,
  output logic              done_ovf_o
);
  logic              filling_q, ovf_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] slot_q;
  logic              take, open_word, fits, ovf_n;
  logic [LEN_W-1:0]  idx, cnt_n;

  assign in_ready_o = filling_q | slot_free_i;
  assign take       = in_valid_i & in_ready_o;
  // words outside an open event without a start marker are dropped
  assign open_word  = take & (filling_q | in_sop_i);
  assign start_o    = take & ~filling_q & in_sop_i;
  assign idx        = start_o ? '0 : cnt_q;
  assign fits       = idx < LEN_W'(SLOT_WORDS);
  assign cnt_n      = fits ? idx + LEN_W'(1) : idx;
  assign ovf_n      = (~start_o & ovf_q) | ~fits;

  assign wr_en_o    = open_word & fits;
  assign wr_slot_o  = slot_q;
  assign wr_idx_o   = idx[IDX_W-1:0];
  assign wr_data_o  = in_data_i;
  assign done_o     = open_word & in_eop_i;
  assign done_len_o = cnt_n;
  assign done_ovf_o = ovf_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filling_q <= 1'b0;
      ovf_q     <= 1'b0;
      cnt_q     <= '0;
      slot_q    <= '0;
    end else if (open_word) begin
      filling_q <= ~in_eop_i;
      cnt_q     <= cnt_n;
      ovf_q     <= ovf_n;
      if (in_eop_i)
        slot_q <= (slot_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot_q + SLOT_W'(1);
    end
  end

  assert_trunc_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && done_ovf_o |-> done_len_o == LEN_W'(SLOT_WORDS));
endmodule

// File: rtl/eb_store.sv
module eb_store #(
  parameter int NUM_SLOTS  = 8,
  parameter int SLOT_WORDS = 16,
  parameter int DATA_W     = 16,
  parameter int SLOT_W     = $clog2(NUM_SLOTS),
  parameter int IDX_W      = $clog2(SLOT_WORDS)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int Words  = NUM_SLOTS * SLOT_WORDS;
  localparam int ADDR_W = $clog2(Words);

  logic [DATA_W-1:0] mem_q [Words];
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  assign wr_addr   = ADDR_W'(wr_slot_i) * ADDR_W'(SLOT_WORDS) + ADDR_W'(wr_idx_i);
  assign rd_addr   = ADDR_W'(rd_slot_i) * ADDR_W'(SLOT_WORDS) + ADDR_W'(rd_idx_i);
  assign rd_data_o = mem_q[rd_addr];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr] <= wr_data_i;
  end
endmodule

// File: rtl/eb_reader.sv
module eb_reader #(
  parameter int NUM_SLOTS  = 8,
  parameter int SLOT_WORDS = 16,
  parameter int DATA_W     = 16,
  parameter int SLOT_W     = $clog2(NUM_SLOTS),
  parameter int IDX_W      = $clog2(SLOT_WORDS),
  parameter int LEN_W      = $clog2(SLOT_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              head_acc_i,
  input  logic              head_rej_i,
  input  logic [LEN_W-1:0]  head_len_i,
  input  logic              head_ovf_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [SLOT_W-1:0] rd_slot_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              free_o,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic              out_ovf_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic              active_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SLOT_W-1:0] head_q;
  logic              last;

  assign rd_slot_o = head_q;
  assign rd_idx_o  = idx_q;
  assign last      = active_q && (LEN_W'(idx_q) + LEN_W'(1) == head_len_i);
  // rejected head is dropped in one idle cycle
  assign free_o    = last | (~active_q & head_rej_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      idx_q       <= '0;
      head_q      <= '0;
      out_valid_o <= 1'b0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
      out_ovf_o   <= 1'b0;
      out_data_o  <= '0;
    end else begin
      if (!active_q && head_acc_i) begin
        active_q <= 1'b1;
        idx_q    <= '0;
      end else if (active_q) begin
        idx_q <= idx_q + IDX_W'(1);
        if (last) active_q <= 1'b0;
      end
      if (free_o)
        head_q <= (head_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : head_q + SLOT_W'(1);
      out_valid_o <= active_q;
      out_sop_o   <= active_q && idx_q == '0;
      out_eop_o   <= last;
      out_ovf_o   <= last & head_ovf_i;
      out_data_o  <= active_q ? rd_data_i : '0;
    end
  end

  assert_contig_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_eop_o |=> out_valid_o);
endmodule

// File: rtl/event_hold_buffer.sv
module event_hold_buffer #(
  parameter int NUM_SLOTS  = 8,
  parameter int SLOT_WORDS = 16,
  parameter int DATA_W     = 16,
  parameter int ERR_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              busy_o,
  input  logic              dec_valid_i,
  input  logic              dec_accept_i,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic              out_ovf_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [ERR_W-1:0]  err_cnt_o
);
  import eb_pkg::*;

  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int IDX_W  = $clog2(SLOT_WORDS);
  localparam int LEN_W  = $clog2(SLOT_WORDS + 1);

  slot_state_e       state_q [NUM_SLOTS];
  logic [LEN_W-1:0]  len_q   [NUM_SLOTS];
  logic              ovf_q   [NUM_SLOTS];
  logic [SLOT_W-1:0] dec_q;
  logic [ERR_W-1:0]  err_q;

  logic              w_en, w_start, w_done, w_ovf;
  logic [SLOT_W-1:0] w_slot, r_slot;
  logic [IDX_W-1:0]  w_idx, r_idx;
  logic [DATA_W-1:0] w_data, r_data;
  logic [LEN_W-1:0]  w_len;
  logic              r_free, dec_hit;

  eb_writer #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_WORDS(SLOT_WORDS), .DATA_W(DATA_W),
    .SLOT_W(SLOT_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_writer (
    .clk_i, .rst_ni, .in_valid_i, .in_sop_i, .in_eop_i, .in_data_i,
    .slot_free_i(state_q[w_slot] == SLOT_FREE),
    .in_ready_o,
    .wr_en_o(w_en), .wr_slot_o(w_slot), .wr_idx_o(w_idx), .wr_data_o(w_data),
    .start_o(w_start), .done_o(w_done), .done_len_o(w_len), .done_ovf_o(w_ovf)
  );

  eb_store #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_WORDS(SLOT_WORDS), .DATA_W(DATA_W),
    .SLOT_W(SLOT_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i,
    .wr_en_i(w_en), .wr_slot_i(w_slot), .wr_idx_i(w_idx), .wr_data_i(w_data),
    .rd_slot_i(r_slot), .rd_idx_i(r_idx), .rd_data_o(r_data)
  );

  eb_reader #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_WORDS(SLOT_WORDS), .DATA_W(DATA_W),
    .SLOT_W(SLOT_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_reader (
    .clk_i, .rst_ni,
    .head_acc_i(state_q[r_slot] == SLOT_ACC),
    .head_rej_i(state_q[r_slot] == SLOT_REJ),
    .head_len_i(len_q[r_slot]), .head_ovf_i(ovf_q[r_slot]),
    .rd_data_i(r_data), .rd_slot_o(r_slot), .rd_idx_o(r_idx), .free_o(r_free),
    .out_valid_o, .out_sop_o, .out_eop_o, .out_ovf_o, .out_data_o
  );

  assign dec_hit   = dec_valid_i && state_q[dec_q] == SLOT_PEND;
  assign err_cnt_o = err_q;

  always_comb begin
    busy_o = 1'b1;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (state_q[s] == SLOT_FREE) busy_o = 1'b0;
  end

  // writer, decision and reader always touch slots in distinct states
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        state_q[s] <= SLOT_FREE;
        len_q[s]   <= '0;
        ovf_q[s]   <= 1'b0;
      end
      dec_q <= '0;
      err_q <= '0;
    end else begin
      if (w_done) begin
        state_q[w_slot] <= SLOT_PEND;
        len_q[w_slot]   <= w_len;
        ovf_q[w_slot]   <= w_ovf;
      end else if (w_start) begin
        state_q[w_slot] <= SLOT_FILL;
      end
      if (dec_hit) begin
        state_q[dec_q] <= dec_accept_i ? SLOT_ACC : SLOT_REJ;
        dec_q <= (dec_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : dec_q + SLOT_W'(1);
      end else if (dec_valid_i && err_q != '1) begin
        err_q <= err_q + ERR_W'(1);
      end
      if (r_free) state_q[r_slot] <= SLOT_FREE;
    end
  end

  assert_alloc_free_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_start |-> state_q[w_slot] == SLOT_FREE);

  assert_release_decided_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_free |-> (state_q[r_slot] == SLOT_ACC || state_q[r_slot] == SLOT_REJ));

  assert_err_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> $stable(err_cnt_o));
endmodule

// File: tb/event_hold_buffer_tb.sv
`timescale 1ns/1ps
module event_hold_buffer_tb;
  localparam int D = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, dec_valid = 0, dec_accept = 0;
  logic [15:0] in_data = '0;
  logic in_ready_o, busy_o, out_valid_o, out_sop_o, out_eop_o, out_ovf_o;
  logic [15:0] out_data_o;
  logic [7:0]  err_cnt_o;

  int checks = 0, fails = 0, exp_err = 0, out_words = 0;
  logic [18:0] exp_q[$];
  logic [15:0] mdl_w_q[$];
  int          mdl_len_q[$];
  bit          mdl_ovf_q[$];

  always #4 clk = ~clk;

  event_hold_buffer u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_sop_i(in_sop), .in_eop_i(in_eop), .in_data_i(in_data),
    .in_ready_o, .busy_o,
    .dec_valid_i(dec_valid), .dec_accept_i(dec_accept),
    .out_valid_o, .out_sop_o, .out_eop_o, .out_ovf_o, .out_data_o, .err_cnt_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] d, input bit s, input bit e);
    in_valid = 1; in_sop = s; in_eop = e; in_data = d;
    while (!in_ready_o) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic send_event(input int n, input logic [15:0] base);
    int kept;
    for (int i = 0; i < n; i++) put(base + 16'(i), i == 0, i == n - 1);
    kept = (n > D) ? D : n;
    for (int i = 0; i < kept; i++) mdl_w_q.push_back(base + 16'(i));
    mdl_len_q.push_back(kept);
    mdl_ovf_q.push_back(n > D);
  endtask

  task automatic decide(input bit acc);
    int n;
    bit ovf;
    logic [15:0] w;
    dec_valid = 1; dec_accept = acc;
    @(negedge clk);
    dec_valid = 0;
    if (mdl_len_q.size() == 0) begin
      if (exp_err < 255) exp_err++;
    end else begin
      n = mdl_len_q.pop_front();
      ovf = mdl_ovf_q.pop_front();
      for (int i = 0; i < n; i++) begin
        w = mdl_w_q.pop_front();
        if (acc) exp_q.push_back({ovf && i == n - 1, i == 0, i == n - 1, w});
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid_o) begin
      logic [18:0] act, exp;
      out_words++;
      act = {out_ovf_o, out_sop_o, out_eop_o, out_data_o};
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R4 unexpected output word", 32'(act), 32'h0);
      end else begin
        exp = exp_q.pop_front();
        chk(act == exp, "R3/R5/R7 output word", 32'(act), 32'(exp));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(out_valid_o == 0, "R9 out_valid", 32'(out_valid_o), 0);
    chk(busy_o == 0, "R9 busy", 32'(busy_o), 0);
    chk(in_ready_o == 1, "R9 in_ready", 32'(in_ready_o), 1);
    chk(err_cnt_o == 0, "R9 err_cnt", 32'(err_cnt_o), 0);

    // R6 stray decision with nothing waiting
    decide(1);
    @(negedge clk);
    chk(err_cnt_o == 8'(exp_err), "R6 stray decision counted", 32'(err_cnt_o), 32'(exp_err));

    // R2 held until decision, then R3 accept
    send_event(4, 16'h0100);
    seen = out_words;
    repeat (8) @(negedge clk);
    chk(out_words == seen, "R2 no output before decision", 32'(out_words), 32'(seen));
    decide(1);
    drain();

    // R4/R5 reject between accepts
    send_event(3, 16'h0200);
    send_event(5, 16'h0300);
    send_event(2, 16'h0400);
    decide(0);
    decide(1);
    decide(0);
    drain();
    chk(exp_q.size() == 0, "R4 rejected events dropped", 32'(exp_q.size()), 0);

    // R3 single-word event
    send_event(1, 16'h0500);
    decide(1);
    drain();

    // R7 exact size and overflow
    send_event(D, 16'h0600);
    send_event(D + 3, 16'h0700);
    decide(1);
    decide(1);
    drain();

    // R11 unframed word is discarded
    put(16'hdead, 0, 1);
    @(negedge clk);
    chk(busy_o == 0 && in_ready_o == 1, "R11 no slot taken", 32'({busy_o, in_ready_o}), 32'h1);
    decide(1);
    @(negedge clk);
    chk(err_cnt_o == 8'(exp_err), "R11 unframed word made no event", 32'(err_cnt_o), 32'(exp_err));

    // R1 fill all slots
    for (int k = 0; k < 8; k++) send_event(2, 16'h1000 + 16'(k * 16));
    @(negedge clk);
    chk(busy_o == 1, "R1 busy when full", 32'(busy_o), 1);
    chk(in_ready_o == 0, "R1 input held off", 32'(in_ready_o), 0);
    // R10 ninth event waits until the first accepted event is sent
    fork
      send_event(3, 16'h2000);
      decide(1);
    join
    chk(busy_o == 1, "R10 freed slot reused", 32'(busy_o), 1);
    for (int k = 0; k < 8; k++) decide(k % 3 != 1);
    drain();
    chk(busy_o == 0, "R10 all slots released", 32'(busy_o), 0);
    chk(in_ready_o == 1, "R10 ready after release", 32'(in_ready_o), 1);

    // R8 decision while another event is arriving
    send_event(3, 16'h3000);
    fork
      send_event(6, 16'h3100);
      begin
        @(negedge clk);
        @(negedge clk);
        decide(1);
      end
    join
    decide(1);
    drain();
    chk(exp_q.size() == 0, "R8 both events delivered", 32'(exp_q.size()), 0);

    // R6 decision when only the decided events exist
    decide(0);
    @(negedge clk);
    chk(err_cnt_o == 8'(exp_err), "R6 err count final", 32'(err_cnt_o), 32'(exp_err));
    chk(mdl_len_q.size() == 0, "R5 verdicts consumed all events", 32'(mdl_len_q.size()), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule